// File: doc/BRIEF.md
# Prioritized Dual-Line Interrupt Identifier

This block collects interrupt requests from a bank of message objects and one error/status source. It keeps a pending flag for every object and routes each object to one of two interrupt lines. For each line it reports the number of the most urgent request routed there. Each object has a one-cycle set strobe and a one-cycle clear strobe that raise and drop its flag. A per-object line-select bit steers a pending object to line 1 when set and to line 0 when clear.

The status source ranks above every object and always goes to line 0. It is active whenever the 8-bit error/status input differs from its idle code 07h, and while it is active line 0 reports the special code 8000h. Both identifiers appear in one 32-bit read-only word. Each line also has an interrupt output, which an enable input can mask.

The read word, the identifiers and the interrupt outputs are plain control and status signals. They have no handshake, and the read word is valid on every cycle.

Top module: `irq_ident_top`

## Requirements
- R1: The read word carries the line-0 identifier in bits 15:0 and the line-1 identifier in bits 23:16. Bits 31:24 always read 0.
- R2: A synchronous active-high reset clears every pending flag. After reset the read word is 0 and both interrupt outputs are low.
- R3: A set strobe sets the object's pending flag at the clock edge that samples the strobe. The identifiers and outputs show the change at the following edge.
- R4: A clear strobe removes an object's pending flag. The identifier then moves to the next most urgent pending source on that line.
- R5: When an object's set and clear strobes arrive in the same cycle, the object ends up pending.
- R6: An identifier names a message object by its number, 1 to 64 (object index plus one). The lowest-numbered pending object on a line wins.
- R7: An object whose line-select bit is 1 appears only on line 1. An object whose line-select bit is 0 appears only on line 0.
- R8: While the error/status input is not 07h, the line-0 identifier is 8000h regardless of pending objects. The line-1 identifier is unaffected by the status source.
- R9: Each interrupt output is high exactly when its registered identifier is nonzero and its enable was high at the same update edge. The output changes one clock after its enable changes.
- R10: Clearing a line enable does not change that line's identifier in the read word.
- R11: An identifier reads 0 when no source routed to that line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 64 | Per-object set strobes, one cycle |
| clr_stb | input | 64 | Per-object clear strobes, one cycle |
| line_sel | input | 64 | Per-object routing, 1 selects line 1 |
| err_status | input | 8 | Error/status value, 07h means idle |
| line0_en | input | 1 | Enable for the line-0 interrupt output |
| line1_en | input | 1 | Enable for the line-1 interrupt output |
| rd_word | output | 32 | Read-only identifier word |
| irq0 | output | 1 | Line-0 interrupt output |
| irq1 | output | 1 | Line-1 interrupt output |

## Verification
The bench builds the block with its default parameters: 64 objects, an 8-bit line-1 field, a 16-bit line-0 field and an idle status code of 07h. These defaults put both ends of the object range within reach, so object 1 and object 64 (40h) are driven on either line. The status code 8000h can be seen pre-empting line 0 while line 1 keeps its own winner. The bench also covers the order in which objects drain as they are cleared one by one, a set and a clear colliding on the same object, and the one-cycle response of the outputs to their enables.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
  localparam int unsigned WORD_W = 32;

  function automatic int unsigned bits_for(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_stb,
  input  logic [N-1:0] clr_stb,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             pend[g] <= 1'b0;
      else if (set_stb[g]) pend[g] <= 1'b1;
      else if (clr_stb[g]) pend[g] <= 1'b0;
    end

    // R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (set_stb[g] && clr_stb[g]) |=> pend[g]);

    // R4
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_stb[g] && !set_stb[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 64,
  parameter int unsigned OUT_W = 8
) (
  input  logic [N-1:0]     req,
  output logic [OUT_W-1:0] id
);
  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = OUT_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_ident_top.sv
module irq_ident_top #(
  parameter int unsigned NUM_OBJ     = 64,
  parameter int unsigned ID1_W       = 8,
  parameter int unsigned ID0_W       = 16,
  parameter int unsigned STAT_W      = 8,
  parameter logic [7:0]  STAT_IDLE   = 8'h07,
  parameter logic [15:0] STATUS_CODE = 16'h8000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] set_stb,
  input  logic [NUM_OBJ-1:0] clr_stb,
  input  logic [NUM_OBJ-1:0] line_sel,
  input  logic [STAT_W-1:0]  err_status,
  input  logic               line0_en,
  input  logic               line1_en,
  output logic [31:0]        rd_word,
  output logic               irq0,
  output logic               irq1
);
  import irq_ident_pkg::*;

  localparam int unsigned PAD_W = WORD_W - ID1_W - ID0_W;

  logic [NUM_OBJ-1:0] pend;
  logic [NUM_OBJ-1:0] req0, req1;
  logic [ID0_W-1:0]   msg_id0, id0_nxt, id0_q;
  logic [ID1_W-1:0]   id1_nxt, id1_q;
  logic               stat_act;
  logic               irq0_q, irq1_q;

  irq_pend_bank #(.N(NUM_OBJ)) u_bank (
    .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb), .pend(pend)
  );

  assign req0 = pend & ~line_sel;
  assign req1 = pend & line_sel;

  irq_prio_enc #(.N(NUM_OBJ), .OUT_W(ID0_W)) u_enc0 (.req(req0), .id(msg_id0));
  irq_prio_enc #(.N(NUM_OBJ), .OUT_W(ID1_W)) u_enc1 (.req(req1), .id(id1_nxt));

  assign stat_act = (err_status != STAT_W'(STAT_IDLE));
  assign id0_nxt  = stat_act ? ID0_W'(STATUS_CODE) : msg_id0;

  always_ff @(posedge clk) begin
    if (rst) begin
      id0_q  <= '0;
      id1_q  <= '0;
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      id0_q  <= id0_nxt;
      id1_q  <= id1_nxt;
      irq0_q <= (id0_nxt != '0) && line0_en;
      irq1_q <= (id1_nxt != '0) && line1_en;
    end
  end

  assign rd_word = {{PAD_W{1'b0}}, id1_q, id0_q};
  assign irq0    = irq0_q;
  assign irq1    = irq1_q;

  // R11
  line1_zero_iff_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((|req1) == (id1_nxt != '0)));

  // R6
  line1_winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (id1_nxt != '0) |-> req1[int'(id1_nxt) - 1]);

  // R6
  line0_no_better_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_id0 != '0) |->
      ((req0 & ((NUM_OBJ'(1) << (int'(msg_id0) - 1)) - NUM_OBJ'(1))) == '0));

  // R8
  status_preempts_chk: assert property (@(posedge clk) disable iff (rst)
    stat_act |=> (id0_q == ID0_W'(STATUS_CODE)));

  // R9
  irq1_needs_id_chk: assert property (@(posedge clk) disable iff (rst)
    irq1_q |-> (id1_q != '0));

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_word[31:24] == 8'h00);
endmodule

// File: tb/tb_irq_ident_top.sv
module tb_irq_ident_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] set_stb, clr_stb, line_sel;
  logic [7:0]  err_status;
  logic        line0_en, line1_en;
  logic [31:0] rd_word;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] pend_m;

  always #2.5 clk = ~clk;

  irq_ident_top dut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb),
    .line_sel(line_sel), .err_status(err_status), .line0_en(line0_en),
    .line1_en(line1_en), .rd_word(rd_word), .irq0(irq0), .irq1(irq1)
  );

  function automatic logic [15:0] exp_id0();
    if (err_status != 8'h07) return 16'h8000;
    for (int i = 0; i < 64; i++) if (pend_m[i] && !line_sel[i]) return 16'(i + 1);
    return 16'h0;
  endfunction

  function automatic logic [7:0] exp_id1();
    for (int i = 0; i < 64; i++) if (pend_m[i] && line_sel[i]) return 8'(i + 1);
    return 8'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic verify(input string tag);
    logic [15:0] e0;
    logic [7:0]  e1;
    e0 = exp_id0();
    e1 = exp_id1();
    chk({tag, " word"}, rd_word, {8'h00, e1, e0});
    chk({tag, " irq0"}, 32'(irq0), 32'((e0 != 0) && line0_en));
    chk({tag, " irq1"}, 32'(irq1), 32'((e1 != 0) && line1_en));
  endtask

  task automatic strobe(input logic [63:0] s, input logic [63:0] c);
    @(negedge clk);
    set_stb = s;
    clr_stb = c;
    @(negedge clk);
    set_stb = '0;
    clr_stb = '0;
    pend_m = s | (pend_m & ~c);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pend_m = '0;
    chk("R2 reset word", rd_word, 32'h0);
    chk("R2 reset irqs", {30'h0, irq1, irq0}, 32'h0);
  endtask

  task automatic t_single();
    strobe(64'h1 << 4, '0);
    verify("R3 R1 single object 5");
    chk("R6 id0 is 5", 32'(rd_word[15:0]), 32'h5);
  endtask

  task automatic t_priority_drain();
    strobe((64'h1 << 39) | (64'h1 << 2), '0);
    verify("R6 lowest number wins");
    strobe('0, 64'h1 << 2);
    verify("R4 drain to 5");
    strobe('0, 64'h1 << 4);
    verify("R4 drain to 40");
    chk("R4 id0 is 40", 32'(rd_word[15:0]), 32'd40);
  endtask

  task automatic t_routing();
    @(negedge clk);
    line_sel = (64'h1 << 63) | 64'h1;
    strobe((64'h1 << 63), '0);
    verify("R7 object 64 on line1");
    chk("R7 id1 is 40h", 32'(rd_word[23:16]), 32'h40);
    strobe(64'h1, '0);
    verify("R7 object 1 on line1");
    chk("R7 line0 keeps 40", 32'(rd_word[15:0]), 32'd40);
  endtask

  task automatic t_status();
    @(negedge clk);
    err_status = 8'h1F;
    @(negedge clk);
    verify("R8 status preempts");
    chk("R8 code", 32'(rd_word[15:0]), 32'h8000);
    chk("R8 line1 unaffected", 32'(rd_word[23:16]), 32'h1);
    @(negedge clk);
    err_status = 8'h07;
    @(negedge clk);
    verify("R8 status released");
  endtask

  task automatic t_collision();
    strobe(64'h1 << 9, 64'h1 << 9);
    verify("R5 set wins");
    chk("R5 id0 is 10", 32'(rd_word[15:0]), 32'd10);
    strobe('0, 64'h1 << 9);
    verify("R4 clear 10");
  endtask

  task automatic t_enables();
    @(negedge clk);
    line0_en = 1'b0;
    @(negedge clk);
    chk("R9 irq0 masked", 32'(irq0), 32'h0);
    chk("R10 id0 kept", 32'(rd_word[15:0]), 32'(exp_id0()));
    verify("R10 word with mask");
    @(negedge clk);
    line0_en = 1'b1;
    line1_en = 1'b0;
    @(negedge clk);
    chk("R9 irq0 back", 32'(irq0), 32'h1);
    chk("R9 irq1 masked", 32'(irq1), 32'h0);
    verify("R10 line1 mask");
    @(negedge clk);
    line1_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_empty();
    strobe('0, '1);
    verify("R11 all clear");
    chk("R11 word zero", rd_word, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    set_stb = '0; clr_stb = '0; line_sel = '0;
    err_status = 8'h07; line0_en = 1'b1; line1_en = 1'b1;
    pend_m = '0;
    t_reset();
    t_single();
    t_priority_drain();
    t_routing();
    t_status();
    t_collision();
    t_enables();
    t_empty();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule